// File: doc/BRIEF.md
# Interrupt Latency History Recorder

This block keeps a short circular log of interrupts as they are serviced, so that the delay between a source asking for service and the service starting can be read back later. Each source has its own raise timestamp register. It is reloaded with the free-running cycle value whenever that source shows up in the newly-set mask on `raise_i`. When the interrupt controller accepts a source (`take_i` with `take_id_i`), a log entry is written. The entry holds the source id, the current cycle as the take time, and that source's stored raise time.

Software or a debug agent reads the log through a combinational port. Slot 0 is the most recent entry, slot 1 the one before it, and so on. The port also returns the latency, which is the take time minus the raise time. The cycle count fed to the block starts at 1, so a take time of zero marks a slot that was never written. Such a slot ends the listing. A running total counts serviced interrupts and direct software raises.

Top module: `irq_lat_log`

## Requirements
- R1: On a clock edge where `raise_i[s]` is 1, the raise timestamp of source s becomes `cycle_i`. Several sources raised in the same cycle are each stamped, and a later raise overwrites an earlier stamp.
- R2: On a clock edge where `take_i` is 1, the entry at the write position receives three values: `take_id_i`, `cycle_i` as the take time, and the raise timestamp of that source as it stood before this edge. A raise of the same source in the same cycle does not affect the entry.
- R3: Every take moves the write position one slot forward. After slot DEPTH-1 it goes back to slot 0, so the oldest entry is overwritten.
- R4: Reset (`rst_ni` low) clears the write position, every entry, every raise timestamp and the total counter to zero.
- R5: Read slot k returns the entry at physical position (write position - k - 1) modulo DEPTH, combinationally from `rd_slot_i`.
- R6: `rd_valid_o` is 1 only if the addressed entry has a nonzero take time and so does every newer slot. When it is 0, `rd_id_o`, `rd_raised_o`, `rd_taken_o` and `rd_latency_o` are all zero.
- R7: For a valid slot, `rd_latency_o` equals `rd_taken_o - rd_raised_o` (TS_W-bit difference). A source taken without any raise since reset reports raise time 0.
- R8: `total_o` increases by 1 for each take, by 1 for each `sw_raise_i` pulse, and by 2 when both occur in one cycle. It wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cycle_i | input | TS_W | Free-running cycle count, starting at 1 |
| raise_i | input | NUM_SRC | Newly-set pending mask, one bit per source |
| sw_raise_i | input | 1 | Direct software raise pulse (counted only) |
| take_i | input | 1 | An interrupt is being serviced this cycle |
| take_id_i | input | ID_W | Source id being serviced |
| rd_slot_i | input | IDX_W | Read slot, 0 = newest |
| rd_valid_o | output | 1 | Addressed slot holds a logged entry |
| rd_id_o | output | ID_W | Logged source id |
| rd_raised_o | output | TS_W | Logged raise time |
| rd_taken_o | output | TS_W | Logged take time |
| rd_latency_o | output | TS_W | Take time minus raise time |
| total_o | output | CNT_W | Count of takes plus software raises |

## Verification
A wrong write position shows up on the first read after the next take. Slot 0 would then return a stale or zeroed entry, and the validity chain would end early or run on through empty slots. A stale or misrouted raise timestamp shows up only when that source is next taken, as a wrong raise time and latency in slot 0. For that reason the bench stamps every source and takes each one, including a source taken with no raise since reset and a raise that coincides with a take. It reads every slot back after each take, and it wraps the log several times so that overwrite order is exercised.

// File: rtl/irq_lat_pkg.sv
package irq_lat_pkg;
    localparam int unsigned NUM_SRC_DEF = 8;
    localparam int unsigned DEPTH_DEF   = 8;
    localparam int unsigned TS_W_DEF    = 32;
    localparam int unsigned CNT_W_DEF   = 16;
endpackage

// File: rtl/irq_lat_stamp.sv
module irq_lat_stamp #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned TS_W    = 32,
    parameter int unsigned ID_W    = 3
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_SRC-1:0]             raise_i,
    input  logic [TS_W-1:0]                cycle_i,
    input  logic [ID_W-1:0]                sel_i,
    output logic [NUM_SRC-1:0][TS_W-1:0]   stamps_o,
    output logic [TS_W-1:0]                sel_stamp_o
);
    localparam logic [ID_W:0] NSRC_X = NUM_SRC[ID_W:0];

    typedef struct packed {
        logic [NUM_SRC-1:0][TS_W-1:0] stamp;
    } stamp_state_t;

    stamp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < int'(NUM_SRC); s++) begin
            if (raise_i[s]) begin
                st_d.stamp[s] = cycle_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamps_o    = st_q.stamp;
    assign sel_stamp_o = ({1'b0, sel_i} < NSRC_X) ? st_q.stamp[sel_i] : '0;
endmodule

// File: rtl/irq_lat_ring.sv
module irq_lat_ring #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned TS_W  = 32,
    parameter int unsigned ID_W  = 3,
    parameter int unsigned IDX_W = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         take_i,
    input  logic [ID_W-1:0]              take_id_i,
    input  logic [TS_W-1:0]              cycle_i,
    input  logic [TS_W-1:0]              raised_i,
    output logic [IDX_W-1:0]             wr_idx_o,
    output logic [DEPTH-1:0][ID_W-1:0]   ids_o,
    output logic [DEPTH-1:0][TS_W-1:0]   raised_o,
    output logic [DEPTH-1:0][TS_W-1:0]   taken_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0]            idx;
        logic [DEPTH-1:0][ID_W-1:0]  id;
        logic [DEPTH-1:0][TS_W-1:0]  raised;
        logic [DEPTH-1:0][TS_W-1:0]  taken;
    } ring_state_t;

    ring_state_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (take_i) begin
            rg_d.id[rg_q.idx]     = take_id_i;
            rg_d.raised[rg_q.idx] = raised_i;
            rg_d.taken[rg_q.idx]  = cycle_i;
            if (rg_q.idx == LAST_IDX) begin
                rg_d.idx = '0;
            end else begin
                rg_d.idx = rg_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign wr_idx_o = rg_q.idx;
    assign ids_o    = rg_q.id;
    assign raised_o = rg_q.raised;
    assign taken_o  = rg_q.taken;
endmodule

// File: rtl/irq_lat_read.sv
module irq_lat_read #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned TS_W  = 32,
    parameter int unsigned ID_W  = 3,
    parameter int unsigned IDX_W = 3
) (
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [DEPTH-1:0][ID_W-1:0]   ids_i,
    input  logic [DEPTH-1:0][TS_W-1:0]   raised_i,
    input  logic [DEPTH-1:0][TS_W-1:0]   taken_i,
    input  logic [IDX_W-1:0]             rd_slot_i,
    output logic                         rd_valid_o,
    output logic [ID_W-1:0]              rd_id_o,
    output logic [TS_W-1:0]              rd_raised_o,
    output logic [TS_W-1:0]              rd_taken_o,
    output logic [TS_W-1:0]              rd_latency_o
);
    localparam logic [IDX_W:0] DEPTH_X = DEPTH[IDX_W:0];

    logic [DEPTH-1:0]            nz;
    logic [DEPTH-1:0][IDX_W-1:0] pos;
    logic [DEPTH-1:0]            chain_ok;

    for (genvar j = 0; j < int'(DEPTH); j++) begin : g_nz
        assign nz[j] = (taken_i[j] != '0);
    end

    for (genvar k = 0; k < int'(DEPTH); k++) begin : g_slot
        logic [IDX_W:0] sum;
        logic [IDX_W:0] wrapped;
        assign sum     = {1'b0, wr_idx_i} + DEPTH_X - (IDX_W+1)'(k + 1);
        assign wrapped = (sum >= DEPTH_X) ? (sum - DEPTH_X) : sum;
        assign pos[k]  = wrapped[IDX_W-1:0];
        if (k == 0) begin : g_first
            assign chain_ok[k] = nz[pos[k]];
        end else begin : g_next
            assign chain_ok[k] = chain_ok[k-1] & nz[pos[k]];
        end
    end

    logic             in_range;
    logic [IDX_W-1:0] phys;

    always_comb begin
        in_range     = ({1'b0, rd_slot_i} < DEPTH_X);
        phys         = in_range ? pos[rd_slot_i] : '0;
        rd_valid_o   = in_range && chain_ok[rd_slot_i];
        rd_id_o      = '0;
        rd_raised_o  = '0;
        rd_taken_o   = '0;
        rd_latency_o = '0;
        if (rd_valid_o) begin
            rd_id_o      = ids_i[phys];
            rd_raised_o  = raised_i[phys];
            rd_taken_o   = taken_i[phys];
            rd_latency_o = taken_i[phys] - raised_i[phys];
        end
    end
endmodule

// File: rtl/irq_lat_log.sv
module irq_lat_log
    import irq_lat_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF,
    parameter int unsigned DEPTH   = DEPTH_DEF,
    parameter int unsigned TS_W    = TS_W_DEF,
    parameter int unsigned CNT_W   = CNT_W_DEF,
    localparam int unsigned ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [TS_W-1:0]    cycle_i,
    input  logic [NUM_SRC-1:0] raise_i,
    input  logic               sw_raise_i,
    input  logic               take_i,
    input  logic [ID_W-1:0]    take_id_i,
    input  logic [IDX_W-1:0]   rd_slot_i,
    output logic               rd_valid_o,
    output logic [ID_W-1:0]    rd_id_o,
    output logic [TS_W-1:0]    rd_raised_o,
    output logic [TS_W-1:0]    rd_taken_o,
    output logic [TS_W-1:0]    rd_latency_o,
    output logic [CNT_W-1:0]   total_o
);
    logic [NUM_SRC-1:0][TS_W-1:0] stamps;
    logic [TS_W-1:0]              sel_stamp;
    logic [IDX_W-1:0]             wr_idx;
    logic [DEPTH-1:0][ID_W-1:0]   ids_arr;
    logic [DEPTH-1:0][TS_W-1:0]   raised_arr;
    logic [DEPTH-1:0][TS_W-1:0]   taken_arr;

    irq_lat_stamp #(
        .NUM_SRC (NUM_SRC),
        .TS_W    (TS_W),
        .ID_W    (ID_W)
    ) stamp_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raise_i     (raise_i),
        .cycle_i     (cycle_i),
        .sel_i       (take_id_i),
        .stamps_o    (stamps),
        .sel_stamp_o (sel_stamp)
    );

    irq_lat_ring #(
        .DEPTH (DEPTH),
        .TS_W  (TS_W),
        .ID_W  (ID_W),
        .IDX_W (IDX_W)
    ) ring_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .take_i    (take_i),
        .take_id_i (take_id_i),
        .cycle_i   (cycle_i),
        .raised_i  (sel_stamp),
        .wr_idx_o  (wr_idx),
        .ids_o     (ids_arr),
        .raised_o  (raised_arr),
        .taken_o   (taken_arr)
    );

    irq_lat_read #(
        .DEPTH (DEPTH),
        .TS_W  (TS_W),
        .ID_W  (ID_W),
        .IDX_W (IDX_W)
    ) read_i (
        .wr_idx_i     (wr_idx),
        .ids_i        (ids_arr),
        .raised_i     (raised_arr),
        .taken_i      (taken_arr),
        .rd_slot_i    (rd_slot_i),
        .rd_valid_o   (rd_valid_o),
        .rd_id_o      (rd_id_o),
        .rd_raised_o  (rd_raised_o),
        .rd_taken_o   (rd_taken_o),
        .rd_latency_o (rd_latency_o)
    );

    typedef struct packed {
        logic [CNT_W-1:0] total;
    } cnt_state_t;

    cnt_state_t cn_d, cn_q;

    always_comb begin
        cn_d       = cn_q;
        cn_d.total = cn_q.total + {{(CNT_W-1){1'b0}}, take_i}
                                + {{(CNT_W-1){1'b0}}, sw_raise_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cn_q <= '0;
        end else begin
            cn_q <= cn_d;
        end
    end

    assign total_o = cn_q.total;
endmodule

// File: rtl/irq_lat_log_chk.sv
module irq_lat_log_chk #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned TS_W    = 32,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ID_W    = 3,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [TS_W-1:0]               cycle_i,
    input  logic [NUM_SRC-1:0]            raise_i,
    input  logic                          sw_raise_i,
    input  logic                          take_i,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [NUM_SRC-1:0][TS_W-1:0]  stamps,
    input  logic [DEPTH-1:0][TS_W-1:0]    taken_arr,
    input  logic                          rd_valid_o,
    input  logic [TS_W-1:0]               rd_taken_o,
    input  logic [TS_W-1:0]               rd_id_unused,
    input  logic [CNT_W-1:0]              total_o
);
    localparam logic [IDX_W:0] DEPTH_X = DEPTH[IDX_W:0];

    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, wr_idx} < DEPTH_X); // R3

    AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> $stable(wr_idx)); // R3

    AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> ({1'b0, wr_idx} == (({1'b0, $past(wr_idx)} + 1'b1) % DEPTH_X))); // R3

    AST_TAKEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> taken_arr[$past(wr_idx)] == $past(cycle_i)); // R2

    AST_VALID_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> rd_taken_o != '0); // R6

    AST_TOTAL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> total_o == $past(total_o) + CNT_W'($past(take_i)) + CNT_W'($past(sw_raise_i))); // R8

    for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_src
        AST_STAMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            raise_i[s] |=> stamps[s] == $past(cycle_i)); // R1
        AST_STAMP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !raise_i[s] |=> $stable(stamps[s])); // R1
    end
endmodule

bind irq_lat_log irq_lat_log_chk #(
    .NUM_SRC (NUM_SRC),
    .DEPTH   (DEPTH),
    .TS_W    (TS_W),
    .CNT_W   (CNT_W),
    .ID_W    (ID_W),
    .IDX_W   (IDX_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cycle_i      (cycle_i),
    .raise_i      (raise_i),
    .sw_raise_i   (sw_raise_i),
    .take_i       (take_i),
    .wr_idx       (wr_idx),
    .stamps       (stamps),
    .taken_arr    (taken_arr),
    .rd_valid_o   (rd_valid_o),
    .rd_taken_o   (rd_taken_o),
    .rd_id_unused (rd_latency_o),
    .total_o      (total_o)
);

// File: tb/irq_lat_log_tb_top.sv
`timescale 1ns/1ps
module irq_lat_log_tb_top;
    localparam int S  = 4;
    localparam int D  = 4;
    localparam int TW = 32;
    localparam int CW = 8;
    localparam int IW = 2;
    localparam int XW = 2;

    logic          clk = 1'b0;
    logic          rst_ni;
    logic [TW-1:0] cycle_i;
    logic [S-1:0]  raise_i;
    logic          sw_raise_i;
    logic          take_i;
    logic [IW-1:0] take_id_i;
    logic [XW-1:0] rd_slot_i;
    logic          rd_valid_o;
    logic [IW-1:0] rd_id_o;
    logic [TW-1:0] rd_raised_o;
    logic [TW-1:0] rd_taken_o;
    logic [TW-1:0] rd_latency_o;
    logic [CW-1:0] total_o;

    always #2.5 clk = ~clk;

    irq_lat_log #(.NUM_SRC(S), .DEPTH(D), .TS_W(TW), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .cycle_i(cycle_i), .raise_i(raise_i),
        .sw_raise_i(sw_raise_i), .take_i(take_i), .take_id_i(take_id_i),
        .rd_slot_i(rd_slot_i), .rd_valid_o(rd_valid_o), .rd_id_o(rd_id_o),
        .rd_raised_o(rd_raised_o), .rd_taken_o(rd_taken_o),
        .rd_latency_o(rd_latency_o), .total_o(total_o)
    );

    int          checks = 0;
    int          errors = 0;
    logic [TW-1:0] cyc;
    logic [TW-1:0] mst [S];
    int            ent_id [D];
    logic [TW-1:0] ent_r [D];
    logic [TW-1:0] ent_t [D];
    int            midx;
    int            mtot;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < S; s++) mst[s] = '0;
        for (int j = 0; j < D; j++) begin
            ent_id[j] = 0; ent_r[j] = '0; ent_t[j] = '0;
        end
        midx = 0;
        mtot = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0; raise_i = '0; take_i = 1'b0; sw_raise_i = 1'b0;
        take_id_i = '0; cycle_i = cyc; rd_slot_i = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        model_clear();
    endtask

    task automatic step(input logic [S-1:0] r, input bit t, input int id, input bit sw);
        @(negedge clk);
        raise_i = r; take_i = t; take_id_i = id[IW-1:0]; sw_raise_i = sw; cycle_i = cyc;
        @(posedge clk);
        if (t) begin
            ent_id[midx] = id;
            ent_r[midx]  = mst[id];
            ent_t[midx]  = cyc;
            midx         = (midx + 1) % D;
            mtot++;
        end
        if (sw) mtot++;
        for (int s = 0; s < S; s++) if (r[s]) mst[s] = cyc;
        cyc = cyc + 1;
    endtask

    task automatic idle();
        @(negedge clk);
        raise_i = '0; take_i = 1'b0; sw_raise_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all();
        idle();
        for (int k = 0; k < D; k++) begin
            bit ve;
            int p;
            rd_slot_i = k[XW-1:0];
            #0.2;
            ve = 1'b1;
            for (int j = 0; j <= k; j++) begin
                p = (midx - j - 1 + D) % D;
                if (ent_t[p] == '0) ve = 1'b0;
            end
            p = (midx - k - 1 + D) % D;
            chk(rd_valid_o == ve, "R6 valid chain", 64'(rd_valid_o), 64'(ve));
            if (ve) begin
                chk(rd_id_o == ent_id[p][IW-1:0], "R5 slot id", 64'(rd_id_o), 64'(ent_id[p]));
                chk(rd_raised_o == ent_r[p], "R2 raise time", 64'(rd_raised_o), 64'(ent_r[p]));
                chk(rd_taken_o == ent_t[p], "R2 take time", 64'(rd_taken_o), 64'(ent_t[p]));
                chk(rd_latency_o == ent_t[p] - ent_r[p], "R7 latency",
                    64'(rd_latency_o), 64'(ent_t[p] - ent_r[p]));
            end else begin
                chk({rd_id_o, rd_raised_o, rd_taken_o, rd_latency_o} == '0,
                    "R6 empty slot zero", 64'(rd_taken_o), 64'h0);
            end
        end
        chk(total_o == CW'(mtot), "R8 total", 64'(total_o), 64'(CW'(mtot)));
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc = 32'd1;
        rst_ni = 1'b0;
        model_clear();
        do_reset();
        // R4: everything empty after reset
        check_all();

        // R1: stamp each source, then take each one; R3 wrap via extra takes
        for (int s = 0; s < S; s++) begin
            step(S'(1 << s), 1'b0, 0, 1'b0);
            idle();
        end
        for (int n = 0; n < 2 * D + 1; n++) begin
            step('0, 1'b1, (n * 3) % S, 1'b0);
            check_all();
        end

        // R1: several sources at once, then a re-stamp overwriting one of them
        step(4'b1010, 1'b0, 0, 1'b0);
        idle(); idle();
        step(4'b0010, 1'b0, 0, 1'b0);
        step('0, 1'b1, 1, 1'b0);
        step('0, 1'b1, 3, 1'b0);
        check_all();

        // R2: raise and take of the same source in one cycle uses the old stamp
        step(4'b0001, 1'b1, 0, 1'b0);
        check_all();
        step('0, 1'b1, 0, 1'b0);
        check_all();

        // R8: software raises alone, together with a take, and wrap of the total
        step('0, 1'b0, 0, 1'b1);
        check_all();
        step(4'b0100, 1'b1, 2, 1'b1);
        check_all();
        for (int n = 0; n < 300; n++) step('0, 1'b0, 0, 1'b1);
        check_all();

        // R4/R7: reset mid-run, then take a source never raised since reset
        do_reset();
        check_all();
        step('0, 1'b1, 3, 1'b0);
        check_all();
        // R5/R6: partially filled log, newest first
        step(4'b0001, 1'b0, 0, 1'b0);
        idle(); idle(); idle();
        step('0, 1'b1, 0, 1'b0);
        check_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule